// File: doc/BRIEF.md
# Asynchronous Static Memory Timing Engine

This block turns one read or write request at a time into the strobe waveforms that an external asynchronous static memory expects. The memory can be a plain SRAM, a pseudo-static RAM or a NOR flash. A request carries an address, write data, byte enables and a direction flag. The engine returns read data and a one-cycle completion pulse. On the memory side it drives one of several active-low chip selects, the output-enable and write-enable strobes, an address-valid strobe and active-low byte-lane strobes. It drives either a plain address bus or a data bus that carries the address first and the data afterwards. It can stretch the data phase while the device holds its wait line.

Every access runs through four phases in order: address setup, address hold, data and bus turnaround. Each phase lasts a programmed number of cycles. Reads always take their lengths from the read set. Writes take their lengths from a second set only when extended mode is on. A bank enable input gates acceptance of new requests. Software is expected to clear it while it changes the configuration and to set it again afterwards. The configuration is captured when a request is accepted, so an access that is already running keeps its timing.

Top module: `async_mem_engine`

## Requirements
- R1: After reset all chip selects, output enable, write enable, address-valid and byte-lane strobes are high, the data bus is not driven, rsp_done is low and no access is in progress.
- R2: While cfg_enable is low, req_ready is low and a request has no effect: no chip select goes low.
- R3: cfg_bank_sel holds a value k from 0 to NCS-1. During an access only mem_ce_n[k] is low, and it stays low through the setup, hold and data phases.
- R4: An access that is not multiplexed holds the chip select low with both strobes high for the setup count. The output enable (read) or write enable (write) is then low for the data count. All chip selects are then high for the turnaround count. A setup or data count of 0 counts as 1, and a turnaround count of 0 skips that phase.
- R5: Read data is sampled from mem_dq_in on the last cycle in which mem_oe_n is low. It is presented on rsp_rdata from the rsp_done cycle onward. The bus is never driven while mem_oe_n is low.
- R6: During a write, mem_we_n is low for the data phase and the data bus is driven with the request's write data. The byte-lane strobes equal the inverted byte enables while the chip select is low. Output enable and write enable are never low together.
- R7: With cfg_ext_mode low, a write uses the read setup, hold, data and turnaround counts. With it high, a write uses the write counts.
- R8: Multiplexing is in effect only when cfg_mux_req is set and cfg_mem_type is 1 (PSRAM) or 2 (NOR). Type 0 is SRAM, and type 3 behaves as SRAM. With multiplexing in effect, the data bus carries the low address bits during setup and during a hold phase of the hold count, where 0 means no hold phase. Without multiplexing there is no hold phase.
- R9: mem_adv_n is low exactly during the setup phase when multiplexing is in effect or the type is NOR. It is never low for a non-multiplexed SRAM.
- R10: While cfg_wait_en is high, each data-phase cycle in which mem_wait is high adds one cycle to the data phase. With cfg_wait_en low, mem_wait has no effect.
- R11: rsp_done is high for exactly one cycle, the cycle after the last turnaround cycle, or after the last data cycle when the turnaround count is 0. req_ready is low from acceptance until that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Bank enable; gates acceptance of requests |
| cfg_mem_type | input | 2 | 0 SRAM, 1 PSRAM, 2 NOR, 3 as SRAM |
| cfg_mux_req | input | 1 | Request multiplexed address/data |
| cfg_ext_mode | input | 1 | Writes use the write timing set |
| cfg_wait_en | input | 1 | Honour mem_wait in the data phase |
| cfg_bank_sel | input | $clog2(NCS) | Chip select index |
| cfg_rd_setup | input | CW | Read/common address setup count |
| cfg_rd_hold | input | CW | Read/common address hold count |
| cfg_rd_data | input | CW | Read/common data phase count |
| cfg_rd_turn | input | CW | Read/common turnaround count |
| cfg_wr_setup | input | CW | Write setup count (extended mode) |
| cfg_wr_hold | input | CW | Write hold count (extended mode) |
| cfg_wr_data | input | CW | Write data phase count (extended mode) |
| cfg_wr_turn | input | CW | Write turnaround count (extended mode) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and enabled; request accepted when both are high |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables, active high |
| rsp_rdata | output | DW | Captured read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | NCS | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_adv_n | output | 1 | Active-low address-valid strobe |
| mem_bl_n | output | DW/8 | Active-low byte-lane strobes |
| mem_addr | output | AW | Address bus |
| mem_dq_out | output | DW | Data bus output value |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_in | input | DW | Data bus input value |
| mem_wait | input | 1 | Device wait, active high |

## Verification
The case hardest to reach from the ports is a wait that starts partway through a stretched data phase. The stall has to land on the exact cycles in which the phase counter would otherwise advance, and the read capture has to move to the new last cycle. The bench watches the strobes at every falling edge. It raises mem_wait only during the first data-phase cycles it sees, and it changes mem_dq_in every cycle. From that it knows both how long the stretched phase should be and which data value should end up in rsp_rdata. The same trace-based monitor counts the hold cycles in multiplexed mode, which appear on no port of their own. It takes them as the cycles with the address on the bus while mem_adv_n is high.

// File: rtl/amc_pkg.sv
// Shared types for the asynchronous static memory timing engine.
// Assumes: memory kind is carried as a 2-bit code; phases run in fixed order.
package amc_pkg;

    typedef enum logic [1:0] {
        MK_SRAM  = 2'd0,
        MK_PSRAM = 2'd1,
        MK_NOR   = 2'd2,
        MK_RSVD  = 2'd3
    } mem_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_HOLD  = 3'd2,
        PH_DATA  = 3'd3,
        PH_TURN  = 3'd4
    } phase_e;

endpackage

// File: rtl/amc_timing_sel.sv
// Picks the timing set for the access about to start and works out whether
// the bus is multiplexed and whether the address-valid strobe is used.
// Assumes: configuration inputs are stable when a request is accepted.
module amc_timing_sel
    import amc_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          ext_mode,
    input  logic          is_write,
    input  logic [1:0]    mem_type,
    input  logic          mux_req,
    input  logic [CW-1:0] rd_setup,
    input  logic [CW-1:0] rd_hold,
    input  logic [CW-1:0] rd_data,
    input  logic [CW-1:0] rd_turn,
    input  logic [CW-1:0] wr_setup,
    input  logic [CW-1:0] wr_hold,
    input  logic [CW-1:0] wr_data,
    input  logic [CW-1:0] wr_turn,
    output logic [CW-1:0] sel_setup,
    output logic [CW-1:0] sel_hold,
    output logic [CW-1:0] sel_data,
    output logic [CW-1:0] sel_turn,
    output logic          mux_on,
    output logic          adv_on
);

    logic use_wr_set;
    logic kind_muxable;
    logic kind_nor;

    // Choose the write set only for writes in extended mode.
    always_comb begin
        use_wr_set = ext_mode && is_write;
        sel_setup  = use_wr_set ? wr_setup : rd_setup;
        sel_hold   = use_wr_set ? wr_hold  : rd_hold;
        sel_data   = use_wr_set ? wr_data  : rd_data;
        sel_turn   = use_wr_set ? wr_turn  : rd_turn;
    end

    // Multiplexing only for PSRAM and NOR; NOR always uses address-valid.
    always_comb begin
        kind_nor     = (mem_type == MK_NOR);
        kind_muxable = (mem_type == MK_PSRAM) || kind_nor;
        mux_on       = mux_req && kind_muxable;
        adv_on       = mux_on || kind_nor;
    end

endmodule

// File: rtl/amc_phase_seq.sv
// Phase sequencer: steps setup -> hold -> data -> turnaround with a down
// counter, stalls the data phase on wait, and flags capture and completion.
// Assumes: lengths are held constant by the caller for the whole access.
module amc_phase_seq
    import amc_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len_setup,
    input  logic [CW-1:0] len_hold,
    input  logic [CW-1:0] len_data,
    input  logic [CW-1:0] len_turn,
    input  logic          mux_on,
    input  logic          wait_en,
    input  logic          wait_in,
    output phase_e        phase,
    output logic          capture,
    output logic          finish
);

    logic [CW-1:0] cnt;
    logic          stall;
    logic          cnt_zero;
    logic [CW-1:0] setup_m1;
    logic [CW-1:0] data_m1;
    logic [CW-1:0] hold_m1;
    logic [CW-1:0] turn_m1;

    // Reload values: a zero setup or data count still lasts one cycle.
    always_comb begin
        setup_m1 = (len_setup == '0) ? '0 : len_setup - 1'b1;
        data_m1  = (len_data  == '0) ? '0 : len_data  - 1'b1;
        hold_m1  = len_hold - 1'b1;
        turn_m1  = len_turn - 1'b1;
        cnt_zero = (cnt == '0);
        stall    = (phase == PH_DATA) && wait_en && wait_in;
        capture  = (phase == PH_DATA) && cnt_zero && !stall;
    end

    // Phase register, cycle counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            finish <= 1'b0;
        end else begin
            finish <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SETUP;
                        cnt   <= setup_m1;
                    end
                end
                PH_SETUP: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - 1'b1;
                    end else if (mux_on && (len_hold != '0)) begin
                        phase <= PH_HOLD;
                        cnt   <= hold_m1;
                    end else begin
                        phase <= PH_DATA;
                        cnt   <= data_m1;
                    end
                end
                PH_HOLD: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        phase <= PH_DATA;
                        cnt   <= data_m1;
                    end
                end
                PH_DATA: begin
                    if (stall) begin
                        cnt <= cnt;
                    end else if (!cnt_zero) begin
                        cnt <= cnt - 1'b1;
                    end else if (len_turn != '0) begin
                        phase <= PH_TURN;
                        cnt   <= turn_m1;
                    end else begin
                        phase  <= PH_IDLE;
                        finish <= 1'b1;
                    end
                end
                PH_TURN: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        phase  <= PH_IDLE;
                        finish <= 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/amc_pin_drive.sv
// Decodes the current phase and the latched request into the memory-side
// strobes, chip selects and data bus.
// Assumes: inputs come from registers, so outputs change only after clk.
module amc_pin_drive
    import amc_pkg::*;
#(
    parameter int AW  = 20,
    parameter int DW  = 16,
    parameter int NCS = 4,
    localparam int NBL = DW / 8,
    localparam int BSW = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  phase_e           phase,
    input  logic             is_write,
    input  logic [BSW-1:0]   bank,
    input  logic             mux_on,
    input  logic             adv_on,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [NBL-1:0]   be,
    output logic [NCS-1:0]   ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             adv_n,
    output logic [NBL-1:0]   bl_n,
    output logic [AW-1:0]    addr_out,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe
);

    logic          active;
    logic          addr_on_bus;
    logic          in_data;
    logic [DW-1:0] addr_as_data;

    // Phase decode shared by all strobes.
    always_comb begin
        active      = (phase == PH_SETUP) || (phase == PH_HOLD) || (phase == PH_DATA);
        in_data     = (phase == PH_DATA);
        addr_on_bus = mux_on && ((phase == PH_SETUP) || (phase == PH_HOLD));
    end

    // One chip select per sub-bank, low only for the selected one.
    for (genvar gi = 0; gi < NCS; gi++) begin : g_cs
        assign ce_n[gi] = !(active && (bank == BSW'(gi)));
    end

    // Fit the address onto the data bus for the multiplexed phase.
    if (AW >= DW) begin : g_addr_wide
        assign addr_as_data = addr[DW-1:0];
    end else begin : g_addr_narrow
        assign addr_as_data = {{(DW-AW){1'b0}}, addr};
    end

    // Strobes and bus drive.
    always_comb begin
        oe_n     = !(in_data && !is_write);
        we_n     = !(in_data && is_write);
        adv_n    = !((phase == PH_SETUP) && adv_on);
        bl_n     = active ? ~be : '1;
        addr_out = addr;
        dq_oe    = addr_on_bus || (in_data && is_write);
        dq_out   = addr_on_bus ? addr_as_data : wdata;
    end

endmodule

// File: rtl/async_mem_engine.sv
// Top level: accepts one request when idle and enabled, captures the request
// and the configuration it needs, sequences the phases and returns read data.
// Assumes: configuration changes only while cfg_enable is low.
module async_mem_engine
    import amc_pkg::*;
#(
    parameter int AW  = 20,
    parameter int DW  = 16,
    parameter int NCS = 4,
    parameter int CW  = 4,
    localparam int NBL = DW / 8,
    localparam int BSW = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic [1:0]       cfg_mem_type,
    input  logic             cfg_mux_req,
    input  logic             cfg_ext_mode,
    input  logic             cfg_wait_en,
    input  logic [BSW-1:0]   cfg_bank_sel,
    input  logic [CW-1:0]    cfg_rd_setup,
    input  logic [CW-1:0]    cfg_rd_hold,
    input  logic [CW-1:0]    cfg_rd_data,
    input  logic [CW-1:0]    cfg_rd_turn,
    input  logic [CW-1:0]    cfg_wr_setup,
    input  logic [CW-1:0]    cfg_wr_hold,
    input  logic [CW-1:0]    cfg_wr_data,
    input  logic [CW-1:0]    cfg_wr_turn,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [NBL-1:0]   req_be,
    output logic [DW-1:0]    rsp_rdata,
    output logic             rsp_done,
    output logic [NCS-1:0]   mem_ce_n,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic             mem_adv_n,
    output logic [NBL-1:0]   mem_bl_n,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_dq_out,
    output logic             mem_dq_oe,
    input  logic [DW-1:0]    mem_dq_in,
    input  logic             mem_wait
);

    phase_e         phase;
    logic           start;
    logic           capture;
    logic           finish;
    logic [CW-1:0]  nx_setup, nx_hold, nx_data, nx_turn;
    logic           nx_mux, nx_adv;
    logic [CW-1:0]  q_setup, q_hold, q_data, q_turn;
    logic           q_mux, q_adv, q_write;
    logic [BSW-1:0] q_bank;
    logic [AW-1:0]  q_addr;
    logic [DW-1:0]  q_wdata;
    logic [NBL-1:0] q_be;
    logic [DW-1:0]  rdata_q;

    // Acceptance: enabled and no access in flight.
    always_comb begin
        req_ready = cfg_enable && (phase == PH_IDLE);
        start     = req_valid && req_ready;
    end

    amc_timing_sel #(.CW(CW)) u_sel (
        .ext_mode  (cfg_ext_mode),
        .is_write  (req_write),
        .mem_type  (cfg_mem_type),
        .mux_req   (cfg_mux_req),
        .rd_setup  (cfg_rd_setup),
        .rd_hold   (cfg_rd_hold),
        .rd_data   (cfg_rd_data),
        .rd_turn   (cfg_rd_turn),
        .wr_setup  (cfg_wr_setup),
        .wr_hold   (cfg_wr_hold),
        .wr_data   (cfg_wr_data),
        .wr_turn   (cfg_wr_turn),
        .sel_setup (nx_setup),
        .sel_hold  (nx_hold),
        .sel_data  (nx_data),
        .sel_turn  (nx_turn),
        .mux_on    (nx_mux),
        .adv_on    (nx_adv)
    );

    // Snapshot the request and its timing when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_setup <= '0;
            q_hold  <= '0;
            q_data  <= '0;
            q_turn  <= '0;
            q_mux   <= 1'b0;
            q_adv   <= 1'b0;
            q_write <= 1'b0;
            q_bank  <= '0;
            q_addr  <= '0;
            q_wdata <= '0;
            q_be    <= '0;
        end else if (start) begin
            q_setup <= nx_setup;
            q_hold  <= nx_hold;
            q_data  <= nx_data;
            q_turn  <= nx_turn;
            q_mux   <= nx_mux;
            q_adv   <= nx_adv;
            q_write <= req_write;
            q_bank  <= cfg_bank_sel;
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
            q_be    <= req_be;
        end
    end

    amc_phase_seq #(.CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .len_setup (start ? nx_setup : q_setup),
        .len_hold  (q_hold),
        .len_data  (q_data),
        .len_turn  (q_turn),
        .mux_on    (q_mux),
        .wait_en   (cfg_wait_en),
        .wait_in   (mem_wait),
        .phase     (phase),
        .capture   (capture),
        .finish    (finish)
    );

    // Read data register, loaded on the final data cycle of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture && !q_write) begin
            rdata_q <= mem_dq_in;
        end
    end

    assign rsp_rdata = rdata_q;
    assign rsp_done  = finish;

    amc_pin_drive #(.AW(AW), .DW(DW), .NCS(NCS)) u_pins (
        .phase    (phase),
        .is_write (q_write),
        .bank     (q_bank),
        .mux_on   (q_mux),
        .adv_on   (q_adv),
        .addr     (q_addr),
        .wdata    (q_wdata),
        .be       (q_be),
        .ce_n     (mem_ce_n),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .adv_n    (mem_adv_n),
        .bl_n     (mem_bl_n),
        .addr_out (mem_addr),
        .dq_out   (mem_dq_out),
        .dq_oe    (mem_dq_oe)
    );

endmodule

// File: rtl/amc_checker.sv
// Protocol checks on the memory-side and request-side pins of the engine.
// Assumes: attached to every instance of async_mem_engine by the bind below.
module amc_checker #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_enable,
    input logic           cfg_wait_en,
    input logic           req_ready,
    input logic           rsp_done,
    input logic [NCS-1:0] mem_ce_n,
    input logic           mem_oe_n,
    input logic           mem_we_n,
    input logic           mem_adv_n,
    input logic           mem_dq_oe,
    input logic           mem_wait
);

    p_one_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_ce_n));

    p_disabled_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> !req_ready);

    p_oe_we_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_oe_n || mem_we_n);

    p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    p_adv_inside_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |-> !(&mem_ce_n));

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(&mem_ce_n) |-> !req_ready);

    p_wait_stretches_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) && cfg_wait_en && mem_wait |=> (!mem_oe_n || !mem_we_n));

endmodule

bind async_mem_engine amc_checker #(.NCS(NCS)) u_amc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_enable  (cfg_enable),
    .cfg_wait_en (cfg_wait_en),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_adv_n   (mem_adv_n),
    .mem_dq_oe   (mem_dq_oe),
    .mem_wait    (mem_wait)
);

// File: tb/sim_async_mem_engine.sv
module sim_async_mem_engine;

    localparam int AW  = 20;
    localparam int DW  = 16;
    localparam int NCS = 4;
    localparam int CW  = 4;
    localparam int NBL = DW / 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_enable = 1'b0;
    logic [1:0]     cfg_mem_type = 2'd0;
    logic           cfg_mux_req = 1'b0;
    logic           cfg_ext_mode = 1'b0;
    logic           cfg_wait_en = 1'b0;
    logic [1:0]     cfg_bank_sel = 2'd0;
    logic [CW-1:0]  cfg_rd_setup = 4'd1, cfg_rd_hold = 4'd0, cfg_rd_data = 4'd1, cfg_rd_turn = 4'd0;
    logic [CW-1:0]  cfg_wr_setup = 4'd1, cfg_wr_hold = 4'd0, cfg_wr_data = 4'd1, cfg_wr_turn = 4'd0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic           req_write = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic [NBL-1:0] req_be = '0;
    logic [DW-1:0]  rsp_rdata;
    logic           rsp_done;
    logic [NCS-1:0] mem_ce_n;
    logic           mem_oe_n, mem_we_n, mem_adv_n;
    logic [NBL-1:0] mem_bl_n;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_dq_out;
    logic           mem_dq_oe;
    logic [DW-1:0]  mem_dq_in = '0;
    logic           mem_wait = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    // Trace results of the last access.
    int             t_pre, t_adv, t_oe, t_we, t_turn, t_dqaddr, t_ready_busy, t_done_len;
    int             t_bad_wdata, t_bad_bl;
    logic [NCS-1:0] t_ce_seen;
    logic [DW-1:0]  t_last_rd;

    always #2.5 clk = ~clk;

    async_mem_engine #(.AW(AW), .DW(DW), .NCS(NCS), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_mem_type(cfg_mem_type),
        .cfg_mux_req(cfg_mux_req), .cfg_ext_mode(cfg_ext_mode), .cfg_wait_en(cfg_wait_en),
        .cfg_bank_sel(cfg_bank_sel), .cfg_rd_setup(cfg_rd_setup), .cfg_rd_hold(cfg_rd_hold),
        .cfg_rd_data(cfg_rd_data), .cfg_rd_turn(cfg_rd_turn), .cfg_wr_setup(cfg_wr_setup),
        .cfg_wr_hold(cfg_wr_hold), .cfg_wr_data(cfg_wr_data), .cfg_wr_turn(cfg_wr_turn),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n),
        .mem_bl_n(mem_bl_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_wait(mem_wait)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] kind, input logic mux, input logic ext,
                           input logic wen, input logic [1:0] bank,
                           input int rs, input int rh, input int rd, input int rt,
                           input int ws, input int wh, input int wd, input int wt);
        @(negedge clk);
        cfg_enable   = 1'b0;
        @(negedge clk);
        cfg_mem_type = kind; cfg_mux_req = mux; cfg_ext_mode = ext;
        cfg_wait_en  = wen;  cfg_bank_sel = bank;
        cfg_rd_setup = CW'(rs); cfg_rd_hold = CW'(rh); cfg_rd_data = CW'(rd); cfg_rd_turn = CW'(rt);
        cfg_wr_setup = CW'(ws); cfg_wr_hold = CW'(wh); cfg_wr_data = CW'(wd); cfg_wr_turn = CW'(wt);
        @(negedge clk);
        cfg_enable   = 1'b1;
    endtask

    // Issue one request and record its trace until the done pulse has ended.
    task automatic run_access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                              input logic [NBL-1:0] be, input int wait_cycles);
        bit seen_strobe = 0;
        bit got_done = 0;
        int strobe_cnt = 0;
        t_pre = 0; t_adv = 0; t_oe = 0; t_we = 0; t_turn = 0; t_dqaddr = 0;
        t_ready_busy = 0; t_done_len = 0; t_bad_wdata = 0; t_bad_bl = 0;
        t_ce_seen = '0; t_last_rd = '0;
        @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = wd; req_be = be; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 300 && !got_done; i++) begin
            logic strobe;
            strobe = !mem_oe_n || !mem_we_n;
            if (!(&mem_ce_n)) begin
                t_ce_seen = t_ce_seen | ~mem_ce_n;
                if (req_ready) t_ready_busy++;
                if (mem_bl_n != ~be) t_bad_bl++;
                if (!strobe) t_pre++;
            end
            if (!mem_adv_n) t_adv++;
            if (mem_dq_oe && !strobe && mem_dq_out == a[DW-1:0]) t_dqaddr++;
            if (!mem_oe_n) t_oe++;
            if (!mem_we_n) begin
                t_we++;
                if (!(mem_dq_oe && mem_dq_out == wd)) t_bad_wdata++;
            end
            if (strobe) seen_strobe = 1;
            if (rsp_done) got_done = 1;
            else if (seen_strobe && (&mem_ce_n)) t_turn++;
            // Drive the device side for the cycle now in progress.
            mem_dq_in = DW'(16'hC000 + i);
            if (!mem_oe_n) t_last_rd = mem_dq_in;
            if (strobe) begin
                mem_wait = (strobe_cnt < wait_cycles);
                strobe_cnt++;
            end else begin
                mem_wait = 1'b0;
            end
            @(negedge clk);
        end
        mem_wait = 1'b0;
        if (got_done) t_done_len = 1;
        if (rsp_done) t_done_len++;
        chk(got_done, "R11 done seen", got_done, 1);
        chk(t_done_len == 1, "R11 done width", t_done_len, 1);
        chk(t_ready_busy == 0, "R11 ready low while busy", t_ready_busy, 0);
    endtask

    task automatic t_reset;
        chk(&mem_ce_n, "R1 ce high", mem_ce_n, 4'hF);
        chk(mem_oe_n && mem_we_n && mem_adv_n, "R1 strobes high",
            {mem_oe_n, mem_we_n, mem_adv_n}, 3'b111);
        chk(&mem_bl_n, "R1 lanes high", mem_bl_n, 2'b11);
        chk(!mem_dq_oe, "R1 bus released", mem_dq_oe, 0);
        chk(!rsp_done, "R1 done low", rsp_done, 0);
    endtask

    task automatic t_disabled;
        int bad_ce = 0, bad_rdy = 0;
        @(negedge clk);
        cfg_enable = 1'b0;
        req_valid = 1'b1; req_write = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!(&mem_ce_n)) bad_ce++;
            if (req_ready) bad_rdy++;
        end
        req_valid = 1'b0;
        chk(bad_ce == 0, "R2 no select while disabled", bad_ce, 0);
        chk(bad_rdy == 0, "R2 not ready while disabled", bad_rdy, 0);
    endtask

    task automatic t_read_basic;
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 3, 5, 4, 2, 1, 0, 1, 0);
        run_access(1'b0, 20'h1234, '0, 2'b11, 0);
        chk(t_pre == 3, "R4 setup count", t_pre, 3);
        chk(t_oe == 4, "R4 read data count", t_oe, 4);
        chk(t_turn == 2, "R4 turnaround count", t_turn, 2);
        chk(t_ce_seen == 4'b0100, "R3 bank 2 select", t_ce_seen, 4'b0100);
        chk(t_adv == 0, "R9 no adv for SRAM", t_adv, 0);
        chk(rsp_rdata == t_last_rd, "R5 read capture", rsp_rdata, t_last_rd);
    endtask

    task automatic t_zero_len;
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 0, 0, 0, 0, 1, 0, 1, 0);
        run_access(1'b0, 20'h0042, '0, 2'b11, 0);
        chk(t_pre == 1, "R4 zero setup", t_pre, 1);
        chk(t_oe == 1, "R4 zero data", t_oe, 1);
        chk(t_turn == 0, "R11 no turnaround", t_turn, 0);
        chk(rsp_rdata == t_last_rd, "R5 capture single cycle", rsp_rdata, t_last_rd);
    endtask

    task automatic t_write_sets;
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 2, 0, 3, 1, 5, 0, 6, 3);
        run_access(1'b1, 20'h0777, 16'hBEEF, 2'b01, 0);
        chk(t_pre == 2 && t_we == 3 && t_turn == 1, "R7 write with read set",
            {t_pre[7:0], t_we[7:0], t_turn[7:0]}, 24'h020301);
        chk(t_bad_wdata == 0, "R6 write data on bus", t_bad_wdata, 0);
        chk(t_bad_bl == 0, "R6 lane strobes", t_bad_bl, 0);
        chk(t_oe == 0, "R6 no oe on write", t_oe, 0);
        set_cfg(2'd0, 1'b0, 1'b1, 1'b0, 2'd1, 2, 0, 3, 1, 5, 0, 6, 3);
        run_access(1'b1, 20'h0778, 16'h5A5A, 2'b10, 0);
        chk(t_pre == 5 && t_we == 6 && t_turn == 3, "R7 write with write set",
            {t_pre[7:0], t_we[7:0], t_turn[7:0]}, 24'h050603);
        chk(t_bad_bl == 0, "R6 upper lane only", t_bad_bl, 0);
        run_access(1'b0, 20'h0779, '0, 2'b11, 0);
        chk(t_pre == 2 && t_oe == 3, "R7 read ignores write set",
            {t_pre[7:0], t_oe[7:0]}, 16'h0203);
    endtask

    task automatic t_mux;
        set_cfg(2'd1, 1'b1, 1'b0, 1'b0, 2'd3, 2, 3, 2, 1, 1, 0, 1, 0);
        run_access(1'b0, 20'h0ABCD, '0, 2'b11, 0);
        chk(t_adv == 2, "R9 adv over setup", t_adv, 2);
        chk(t_pre == 5, "R8 setup plus hold", t_pre, 5);
        chk(t_dqaddr == 5, "R8 address on data bus", t_dqaddr, 5);
        set_cfg(2'd0, 1'b1, 1'b0, 1'b0, 2'd3, 2, 3, 2, 1, 1, 0, 1, 0);
        run_access(1'b0, 20'h0ABCD, '0, 2'b11, 0);
        chk(t_pre == 2 && t_dqaddr == 0 && t_adv == 0, "R8 SRAM not multiplexed",
            {t_pre[7:0], t_dqaddr[7:0], t_adv[7:0]}, 24'h020000);
        set_cfg(2'd2, 1'b0, 1'b0, 1'b0, 2'd3, 3, 4, 2, 1, 1, 0, 1, 0);
        run_access(1'b0, 20'h01357, '0, 2'b11, 0);
        chk(t_adv == 3 && t_pre == 3 && t_dqaddr == 0, "R9 NOR adv without mux",
            {t_adv[7:0], t_pre[7:0], t_dqaddr[7:0]}, 24'h030300);
        set_cfg(2'd2, 1'b1, 1'b0, 1'b0, 2'd3, 2, 0, 2, 0, 1, 0, 1, 0);
        run_access(1'b0, 20'h02468, '0, 2'b11, 0);
        chk(t_pre == 2 && t_dqaddr == 2, "R8 zero hold skipped",
            {t_pre[7:0], t_dqaddr[7:0]}, 16'h0202);
    endtask

    task automatic t_wait;
        set_cfg(2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 1, 0, 3, 1, 1, 0, 1, 0);
        run_access(1'b0, 20'h00100, '0, 2'b11, 4);
        chk(t_oe == 7, "R10 data stretched by wait", t_oe, 7);
        chk(rsp_rdata == t_last_rd, "R10 capture after stall", rsp_rdata, t_last_rd);
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1, 0, 3, 1, 1, 0, 1, 0);
        run_access(1'b0, 20'h00101, '0, 2'b11, 4);
        chk(t_oe == 3, "R10 wait ignored when off", t_oe, 3);
    endtask

    task automatic t_banks;
        for (int b = 0; b < NCS; b++) begin
            set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 2'(b), 1, 0, 1, 0, 1, 0, 1, 0);
            run_access(1'b0, AW'(b), '0, 2'b11, 0);
            chk(t_ce_seen == NCS'(1 << b), "R3 select per index", t_ce_seen, 1 << b);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_disabled;
        t_read_basic;
        t_zero_len;
        t_write_sets;
        t_mux;
        t_wait;
        t_banks;
        repeat (3) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule